// File: doc/BRIEF.md
# EEPROM Page Write Protection Controller

This block is a synchronous write controller placed in front of a small byte array that stands in for an EEPROM. It takes bus write events on a 15-bit address space. Each event is an address, a data byte and a one-cycle strobe. The controller gathers one byte, or a burst of up to 64 bytes that belong to a single page, into a page buffer. When the bus has been quiet for a set number of cycles, it runs an internal write cycle. At the end of that cycle the buffered bytes are committed to the array in one step. While the cycle runs, an open-drain style busy flag pulls low. During that time any further write strobe is refused and reported with a one-cycle pulse.

The controller has an optional protection mode. Once protection is on, data is taken only straight after a three-byte unlock prefix. When protection is off, sending the same prefix followed by data writes that data and also turns protection on. A byte that breaks the prefix is not lost. If protection is off, it becomes an ordinary write. Writes are also refused for a fixed interval after reset, which stands in for the supply settling after power-up. All timing values are counts of clock cycles.

Top module: `eeprom_guard_ctrl`

## Requirements
- R1: After reset the busy driver is released (busyPull = 0), wrRejected is 0 and every array location reads 00h.
- R2: For PWRUP_CYC cycles after reset, every write strobe is ignored. It causes no write cycle and no array change.
- R3: With protection off, an accepted byte opens a page load. The internal write cycle starts once BYTE_TMO_CYC cycles pass with no further strobe: busyPull first reads 1 exactly BYTE_TMO_CYC cycles after the clock edge that took the last byte.
- R4: busyPull stays at 1 for exactly WRITE_CYC cycles. The buffered bytes appear on the read port in the same cycle that busyPull returns to 0, and the array holds its contents at all other times.
- R5: A page is 2**PAGE_W = 64 bytes. Address bits [5:0] select the byte within the page. The page itself comes from the first byte of a load; later bytes in the same load use only their bits [5:0]. A repeated offset keeps the last byte written to it.
- R6: A strobe that arrives while busyPull is 1 is ignored. wrRejected is then 1 for exactly one cycle, on the cycle after that strobe.
- R7: The unlock prefix is the sequence AAh at 5555h, then 55h at 2AAAh, then A0h at 5555h. The prefix bytes are not written to the array. The next byte opens a page load, and protection is on from the end of that write cycle.
- R8: While protection is on, a byte that does not follow a complete prefix is ignored: no write cycle and no array change. Protection remains on after a protected write completes.
- R9: When a byte breaks the prefix, any prefix bytes already received are dropped. With protection off, the breaking byte is handled as an ordinary write.
- R10: If BYTE_TMO_CYC cycles pass between two prefix bytes, the prefix is abandoned and the next byte is judged from the start of the sequence.
- R11: The array holds 2**MEM_AW bytes, and write addresses wrap modulo that depth: a write to 7FFFh lands at index 2**MEM_AW-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStb | input | 1 | Write strobe; one event per cycle it is high |
| wrAddr | input | ADDR_W (15) | Write address |
| wrData | input | DATA_W (8) | Write data byte |
| rdAddr | input | MEM_AW (10) | Array read address |
| rdData | output | DATA_W (8) | Array read data, combinational |
| busyPull | output | 1 | 1 while a write cycle runs (busy pin driven low); 0 means released |
| wrRejected | output | 1 | One-cycle pulse for a strobe refused during a write cycle |

## Verification
The bench builds the block with PWRUP_CYC = 50, BYTE_TMO_CYC = 8 and WRITE_CYC = 20, in place of the defaults of milliseconds. With these values the power-up window, the quiet-bus timeout and the full write cycle can each be measured to the exact cycle, many times in one run. MEM_AW stays at 10, so a 1 KiB array puts the address wrap and the prefix addresses 5555h and 2AAAh (which alias to 155h and 2AAh) within reach of the read port. That lets the bench confirm that prefix bytes never reach the array.

// File: rtl/eeprom_guard_pkg.sv
package eeprom_guard_pkg;

  // Unlock prefix codes; the order of the three steps is behaviour.
  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_DATA_1 = 8'hAA;
  localparam logic [7:0]  KEY_DATA_2 = 8'h55;
  localparam logic [7:0]  KEY_DATA_3 = 8'hA0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_ARMED, ST_LOAD, ST_PROG
  } ctlState_t;

  // Strobes from control to the page datapath.
  typedef struct packed {
    logic startPage;  // clear buffer, latch page, store byte
    logic addByte;    // store byte at its offset
    logic commit;     // copy valid buffer bytes into the array
  } pageCmd_t;

endpackage

// File: rtl/guard_ctl.sv
module guard_ctl
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int PWRUP_CYC    = 625000,
  parameter int BYTE_TMO_CYC = 12500,
  parameter int WRITE_CYC    = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output pageCmd_t          cmd,
  output logic              busyPull,
  output logic              wrRejected
);
  localparam int PU_W   = $clog2(PWRUP_CYC + 1);
  localparam int MAXCYC = (BYTE_TMO_CYC > WRITE_CYC) ? BYTE_TMO_CYC : WRITE_CYC;
  localparam int TK_W   = $clog2(MAXCYC + 1);
  localparam logic [TK_W-1:0] TMO_LAST = TK_W'(BYTE_TMO_CYC - 1);
  localparam logic [TK_W-1:0] WR_LAST  = TK_W'(WRITE_CYC - 1);
  localparam logic [PU_W-1:0] PU_DONE  = PU_W'(PWRUP_CYC);

  ctlState_t st, stNext;
  logic [PU_W-1:0] puCnt;
  logic [TK_W-1:0] tick;
  logic puReady, accept, tickClr;
  logic sdpOn, loadArmed, armNext;
  logic hit1, hit2, hit3, timeoutHit, progDone;

  assign puReady    = (puCnt == PU_DONE);
  assign accept     = wrStb && puReady;
  assign hit1       = (wrAddr == ADDR_W'(KEY_ADDR_A)) && (wrData == DATA_W'(KEY_DATA_1));
  assign hit2       = (wrAddr == ADDR_W'(KEY_ADDR_B)) && (wrData == DATA_W'(KEY_DATA_2));
  assign hit3       = (wrAddr == ADDR_W'(KEY_ADDR_A)) && (wrData == DATA_W'(KEY_DATA_3));
  assign timeoutHit = (tick == TMO_LAST);
  assign progDone   = (tick == WR_LAST);
  assign busyPull   = (st == ST_PROG);

  always_comb begin
    stNext  = st;
    cmd     = '0;
    tickClr = 1'b0;
    armNext = 1'b0;
    case (st)
      ST_IDLE:
        if (accept) begin
          tickClr = 1'b1;
          if (hit1) stNext = ST_KEY1;
          else if (!sdpOn) begin stNext = ST_LOAD; cmd.startPage = 1'b1; end
        end
      ST_KEY1, ST_KEY2:
        if (accept) begin
          tickClr = 1'b1;
          if ((st == ST_KEY1) ? hit2 : hit3)
            stNext = (st == ST_KEY1) ? ST_KEY2 : ST_ARMED;
          else if (!sdpOn) begin stNext = ST_LOAD; cmd.startPage = 1'b1; end
          else stNext = ST_IDLE;
        end else if (timeoutHit) stNext = ST_IDLE;
      ST_ARMED:
        if (accept) begin
          tickClr = 1'b1;
          armNext = 1'b1;
          stNext = ST_LOAD;
          cmd.startPage = 1'b1;
        end else if (timeoutHit) stNext = ST_IDLE;
      ST_LOAD:
        if (accept) begin
          tickClr = 1'b1;
          cmd.addByte = 1'b1;
        end else if (timeoutHit) begin
          tickClr = 1'b1;
          stNext = ST_PROG;
        end
      ST_PROG:
        if (progDone) begin
          cmd.commit = 1'b1;
          stNext = ST_IDLE;
        end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st         <= ST_IDLE;
      puCnt      <= '0;
      tick       <= '0;
      sdpOn      <= 1'b0;
      loadArmed  <= 1'b0;
      wrRejected <= 1'b0;
    end else begin
      st <= stNext;
      if (!puReady) puCnt <= puCnt + 1'b1;
      if (tickClr) tick <= '0;
      else if (st != ST_IDLE) tick <= tick + 1'b1;
      if (cmd.startPage) loadArmed <= armNext;
      if (cmd.commit && loadArmed) sdpOn <= 1'b1;
      wrRejected <= wrStb && (st == ST_PROG);
    end
  end

endmodule

// File: rtl/guard_dp.sv
module guard_dp
  import eeprom_guard_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6,
  parameter int MEM_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  pageCmd_t          cmd,
  input  logic [MEM_AW-1:0] wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MEM_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int MEM_DEPTH  = 1 << MEM_AW;
  localparam int PG_W       = MEM_AW - PAGE_W;

  logic [DATA_W-1:0] mem     [MEM_DEPTH];
  logic [DATA_W-1:0] bufData [PAGE_BYTES];
  logic              bufVld  [PAGE_BYTES];
  logic [PG_W-1:0]   pageBase;
  logic [PAGE_W-1:0] wrOff;

  assign wrOff  = wrIdx[PAGE_W-1:0];
  assign rdData = mem[rdAddr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pageBase <= '0;
    else if (cmd.startPage) pageBase <= wrIdx[MEM_AW-1:PAGE_W];
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLane
    logic laneHit;
    assign laneHit = (wrOff == PAGE_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufVld[g]  <= 1'b0;
        bufData[g] <= '0;
      end else if (cmd.startPage) begin
        bufVld[g] <= laneHit;
        if (laneHit) bufData[g] <= wrData;
      end else if (cmd.addByte && laneHit) begin
        bufVld[g]  <= 1'b1;
        bufData[g] <= wrData;
      end else if (cmd.commit) begin
        bufVld[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
    end else if (cmd.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (bufVld[i]) mem[{pageBase, PAGE_W'(i)}] <= bufData[i];
    end
  end

endmodule

// File: rtl/eeprom_guard_ctrl.sv
module eeprom_guard_ctrl
  import eeprom_guard_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int PAGE_W       = 6,
  parameter int MEM_AW       = 10,
  parameter int PWRUP_CYC    = 625000,
  parameter int BYTE_TMO_CYC = 12500,
  parameter int WRITE_CYC    = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [MEM_AW-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              busyPull,
  output logic              wrRejected
);
  pageCmd_t cmd;

  guard_ctl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWRUP_CYC(PWRUP_CYC),
    .BYTE_TMO_CYC(BYTE_TMO_CYC), .WRITE_CYC(WRITE_CYC)
  ) uCtl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .cmd(cmd), .busyPull(busyPull), .wrRejected(wrRejected)
  );

  guard_dp #(
    .DATA_W(DATA_W), .PAGE_W(PAGE_W), .MEM_AW(MEM_AW)
  ) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrIdx(wrAddr[MEM_AW-1:0]),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );

endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int DATA_W    = 8,
  parameter int MEM_AW    = 10,
  parameter int PWRUP_CYC = 625000,
  parameter int WRITE_CYC = 625000
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStb,
  input logic              busyPull,
  input logic              wrRejected,
  input logic [MEM_AW-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData
);
  localparam int SR_W = $clog2(PWRUP_CYC + 1);
  localparam int BR_W = $clog2(WRITE_CYC + 2);

  logic [SR_W-1:0] sinceRst;
  logic [BR_W-1:0] busyRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      busyRun  <= '0;
    end else begin
      if (sinceRst != SR_W'(PWRUP_CYC)) sinceRst <= sinceRst + 1'b1;
      busyRun <= busyPull ? busyRun + 1'b1 : '0;
    end
  end

  // R2
  pwrup_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != SR_W'(PWRUP_CYC)) |-> !busyPull);

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyPull) |-> (busyRun == BR_W'(WRITE_CYC)));

  // R6
  reject_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrRejected |-> $past(busyPull && wrStb));

  // R3
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyPull) |-> $past(!wrStb));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdAddr) && !$fell(busyPull)) |-> $stable(rdData));

endmodule

bind eeprom_guard_ctrl guard_chk #(
  .DATA_W(DATA_W), .MEM_AW(MEM_AW), .PWRUP_CYC(PWRUP_CYC), .WRITE_CYC(WRITE_CYC)
) uChk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .busyPull(busyPull),
  .wrRejected(wrRejected), .rdAddr(rdAddr), .rdData(rdData)
);

// File: tb/tb_eeprom_guard_ctrl.sv
module tb_eeprom_guard_ctrl;
  localparam int PU  = 50;
  localparam int TMO = 8;
  localparam int WR  = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrStb = 1'b0;
  logic [14:0] wrAddr = '0;
  logic [7:0]  wrData = '0;
  logic [9:0]  rdAddr = '0;
  logic [7:0]  rdData;
  logic busyPull, wrRejected;

  int nChk = 0;
  int nBad = 0;

  always #4 clk = ~clk;

  eeprom_guard_ctrl #(
    .PWRUP_CYC(PU), .BYTE_TMO_CYC(TMO), .WRITE_CYC(WR)
  ) dut (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busyPull(busyPull), .wrRejected(wrRejected)
  );

  // write address, read-back index, data
  localparam logic [32:0] VEC [4] = '{
    {15'h0005, 10'h005, 8'h3C},
    {15'h0123, 10'h123, 8'hC3},
    {15'h03C0, 10'h3C0, 8'h01},
    {15'h7FFF, 10'h3FF, 8'hFE}
  };

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wrAddr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic readChk(input string req, input logic [9:0] a, input logic [7:0] exp);
    rdAddr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic measure(output int dly, output int len);
    dly = 0;
    while (!busyPull && dly < 1000) begin @(negedge clk); dly++; end
    len = 0;
    while (busyPull && len < 1000) begin @(negedge clk); len++; end
  endtask

  task automatic expectQuiet(input string req);
    int seen = 0;
    for (int i = 0; i < TMO + WR + 4; i++) begin
      @(negedge clk);
      if (busyPull) seen = 1;
    end
    chk(req, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int dly, len;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 busy", busyPull, 0);
    chk("R1 rejected", wrRejected, 0);
    readChk("R1 array", 10'h005, 8'h00);

    // R2 write during power-up interval
    strobe(15'h0010, 8'h11);
    expectQuiet("R2 no busy in power-up");
    readChk("R2 array untouched", 10'h010, 8'h00);
    repeat (PU) @(negedge clk);

    // R3 R4 R11 table of plain byte writes
    for (int v = 0; v < 4; v++) begin
      strobe(VEC[v][32:18], VEC[v][7:0]);
      measure(dly, len);
      chk("R3 busy delay", dly, TMO);
      chk("R4 busy length", len, WR);
      readChk("R11 R3 readback", VEC[v][17:8], VEC[v][7:0]);
    end

    // R5 page load, page from first byte, offset overwrite
    strobe(15'h0040, 8'hA1);
    strobe(15'h0041, 8'hA2);
    strobe(15'h007F, 8'hA3);
    strobe(15'h0083, 8'hA4);
    strobe(15'h0041, 8'hB2);
    measure(dly, len);
    chk("R5 page delay", dly, TMO);
    readChk("R5 first", 10'h040, 8'hA1);
    readChk("R5 overwrite", 10'h041, 8'hB2);
    readChk("R5 last offset", 10'h07F, 8'hA3);
    readChk("R5 offset only", 10'h043, 8'hA4);
    readChk("R5 other page", 10'h083, 8'h00);

    // R6 strobe during busy
    strobe(15'h0300, 8'h12);
    while (!busyPull) @(negedge clk);
    strobe(15'h0301, 8'h55);
    chk("R6 reject pulse", wrRejected, 1);
    @(negedge clk);
    chk("R6 pulse width", wrRejected, 0);
    while (busyPull) @(negedge clk);
    expectQuiet("R6 no extra cycle");
    readChk("R6 kept write", 10'h300, 8'h12);
    readChk("R6 refused write", 10'h301, 8'h00);

    // R9 broken prefix, protection off
    strobe(15'h5555, 8'hAA);
    strobe(15'h0200, 8'h44);
    measure(dly, len);
    chk("R9 fallback delay", dly, TMO);
    readChk("R9 fallback data", 10'h200, 8'h44);
    readChk("R9 prefix dropped", 10'h155, 8'h00);

    // R7 unlock prefix plus data enables protection
    strobe(15'h5555, 8'hAA);
    strobe(15'h2AAA, 8'h55);
    strobe(15'h5555, 8'hA0);
    strobe(15'h0100, 8'h5A);
    measure(dly, len);
    chk("R7 delay", dly, TMO);
    chk("R7 length", len, WR);
    readChk("R7 data", 10'h100, 8'h5A);
    readChk("R7 key A not stored", 10'h155, 8'h00);
    readChk("R7 key B not stored", 10'h2AA, 8'h00);

    // R8 plain write now ignored
    strobe(15'h0101, 8'h77);
    expectQuiet("R8 no busy");
    readChk("R8 ignored", 10'h101, 8'h00);
    // R8 protected write accepted
    strobe(15'h5555, 8'hAA);
    strobe(15'h2AAA, 8'h55);
    strobe(15'h5555, 8'hA0);
    strobe(15'h0101, 8'h66);
    measure(dly, len);
    readChk("R8 protected write", 10'h101, 8'h66);
    strobe(15'h0101, 8'h99);
    expectQuiet("R8 still protected");
    readChk("R8 still protected data", 10'h101, 8'h66);
    // R9 broken prefix with protection on
    strobe(15'h5555, 8'hAA);
    strobe(15'h2AAA, 8'h55);
    strobe(15'h0102, 8'h33);
    expectQuiet("R9 broken prefix protected");
    readChk("R9 broken prefix data", 10'h102, 8'h00);

    // R10 timeout between prefix bytes
    strobe(15'h5555, 8'hAA);
    repeat (TMO + 2) @(negedge clk);
    strobe(15'h2AAA, 8'h55);
    strobe(15'h5555, 8'hA0);
    strobe(15'h0103, 8'h21);
    expectQuiet("R10 prefix abandoned");
    readChk("R10 data", 10'h103, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule